// File: doc/BRIEF.md
# Repeat-Loop and Breakpoint PC Sequencer

This block decides where execution goes after each instruction word retires. Every cycle in which `step_i` is high, it takes the current word PC, the status word, the repeat count and the branch result from the execute stage. It then computes and registers the next PC, the next status word and the next repeat count, all committed on the same clock edge.

Four mechanisms compete for the next PC, in a fixed priority:
- An exception request redirects to a fixed vector and masks the status word. A bus error beats an illegal instruction, and both beat everything below.
- An instruction-breakpoint match redirects to a debug vector and saves the PC and status word into backup registers.
- A branch taken by the executing word goes to its target.
- A zero-overhead repeat loop sends execution back to the loop start when the word at the loop end retires, and counts the iterations down.

Without any of these, the PC advances by one. The block also registers the instruction-fetch byte address, which is the word PC shifted left by two.

Top module: `pcseq_top`

## Requirements
- R1: Under synchronous reset the PC is 0xFFC0 (a word address) and the fetch byte address is 0x3FF00. The status word, repeat count, backup PC and backup status word are all zero.
- R2: On a step with no exception, no breakpoint match, no branch and no loop-end hit, the PC becomes the current PC + 1 modulo 2^PC_W. The status word and count pass through unchanged.
- R3: When `pc_chg_i` is set, the PC becomes `tgt_pc_i` and the count passes through unchanged. This holds even when the repeat bit (status bit 7) is set and the PC equals the loop end, so a branch at the loop end wins over the loop-back.
- R4: When there is no branch, status bit 7 is set, the PC equals `rpt_end_i` and the count is greater than 1, the PC becomes `rpt_start_i`. The count decrements by one and the status word is unchanged.
- R5: In the same loop-end situation with a count of 0 or 1, status bit 7 clears, the count becomes 0 and the PC becomes the current PC + 1.
- R6: When the debug-enable bit (status bit 14) is set and the PC equals `bp_addr_i`, the PC becomes DBG_VEC and the status word keeps only bit 15 (stack mode). The backup PC and backup status word take the current PC and status word. The count passes through. This overrides any branch or loop.
- R7: A bus error sends the PC to BUS_VEC and an illegal instruction sends it to ILL_VEC, with the bus error winning if both are raised. The status word keeps only bits 3, 2 and 0 (two flags and carry). The count passes through, and both override breakpoint, branch and loop.
- R8: The fetch byte address always equals the registered PC with two zero bits appended below it.
- R9: While `step_i` is low, every output holds its value, whatever the other inputs do.
- R10: The backup PC and backup status word change only on a breakpoint entry (R6). They hold through exceptions and all other steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | An instruction word retires this cycle |
| cur_pc_i | input | PC_W | Word PC of the retiring word |
| cur_psw_i | input | 16 | Status word before the step |
| cur_cnt_i | input | CNT_W | Repeat count before the step |
| pc_chg_i | input | 1 | The retiring word changed the PC |
| tgt_pc_i | input | PC_W | Branch target when `pc_chg_i` is set |
| rpt_start_i | input | PC_W | Loop start address |
| rpt_end_i | input | PC_W | Loop end address |
| bp_addr_i | input | PC_W | Instruction breakpoint address |
| bus_err_i | input | 1 | Bus-error exception request |
| ill_ins_i | input | 1 | Illegal-instruction exception request |
| pc_o | output | PC_W | Registered next PC |
| fetch_o | output | PC_W+2 | Registered fetch byte address |
| psw_o | output | 16 | Registered next status word |
| cnt_o | output | CNT_W | Registered next repeat count |
| bk_pc_o | output | PC_W | Backup PC saved on breakpoint entry |
| bk_psw_o | output | 16 | Backup status word saved on breakpoint entry |

## Verification
A wrong priority between exception, breakpoint, branch and loop shows up one cycle after the step, as a PC at the wrong vector or target. A wrong loop-end decision shows one cycle later as an off-by-one count or a repeat bit that stays set. A bad status mask is visible in the very next status word. A stray write to the backup registers stays visible until the next breakpoint, so the bench checks them after every step, including steps taken while `step_i` is low.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int PSW_W = 16;
  // status word bit positions
  localparam int B_SM  = 15;  // stack mode, survives breakpoint entry
  localparam int B_DB  = 14;  // debug (breakpoint) enable
  localparam int B_RP  = 7;   // repeat loop active
  localparam int B_F0  = 3;
  localparam int B_F1  = 2;
  localparam int B_CY  = 0;

  localparam logic [PSW_W-1:0] EXC_KEEP =
    (PSW_W'(1) << B_F0) | (PSW_W'(1) << B_F1) | (PSW_W'(1) << B_CY);
  localparam logic [PSW_W-1:0] DBG_KEEP = PSW_W'(1) << B_SM;
endpackage

// File: rtl/pcseq_loop.sv
module pcseq_loop
  import pcseq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PSW_W-1:0] psw_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             chg_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  logic [PC_W-1:0]  start_i,
  input  logic [PC_W-1:0]  end_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic at_end;
  assign at_end = psw_i[B_RP] && (pc_i == end_i);

  // branch first, loop-back only when the word left the PC alone
  always_comb begin
    pc_o  = pc_i + PC_ONE;
    psw_o = psw_i;
    cnt_o = cnt_i;
    if (chg_i) begin
      pc_o = tgt_i;
    end else if (at_end) begin
      if (cnt_i > CNT_ONE) begin
        pc_o  = start_i;
        cnt_o = cnt_i - CNT_ONE;
      end else begin
        psw_o[B_RP] = 1'b0;
        cnt_o       = '0;
      end
    end
  end
endmodule

// File: rtl/pcseq_trap.sv
module pcseq_trap
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int CNT_W    = 16,
  parameter int unsigned DBG_VEC = 'h3FF4,
  parameter int unsigned BUS_VEC = 'h3FEC,
  parameter int unsigned ILL_VEC = 'h3FEE
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PSW_W-1:0] psw_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PC_W-1:0]  bp_i,
  input  logic             bus_i,
  input  logic             ill_i,
  input  logic [PC_W-1:0]  seq_pc_i,
  input  logic [PSW_W-1:0] seq_psw_i,
  input  logic [CNT_W-1:0] seq_cnt_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bk_we_o
);
  localparam logic [PC_W-1:0] V_DBG = PC_W'(DBG_VEC);
  localparam logic [PC_W-1:0] V_BUS = PC_W'(BUS_VEC);
  localparam logic [PC_W-1:0] V_ILL = PC_W'(ILL_VEC);

  logic brk_hit;
  assign brk_hit = psw_i[B_DB] && (pc_i == bp_i);

  always_comb begin
    pc_o    = seq_pc_i;
    psw_o   = seq_psw_i;
    cnt_o   = seq_cnt_i;
    bk_we_o = 1'b0;
    if (bus_i || ill_i) begin
      pc_o  = bus_i ? V_BUS : V_ILL;
      psw_o = psw_i & EXC_KEEP;
      cnt_o = cnt_i;
    end else if (brk_hit) begin
      pc_o    = V_DBG;
      psw_o   = psw_i & DBG_KEEP;
      cnt_o   = cnt_i;
      bk_we_o = 1'b1;
    end
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int CNT_W    = 16,
  parameter int unsigned RESET_PC = 'hFFC0,
  parameter int unsigned DBG_VEC  = 'h3FF4,
  parameter int unsigned BUS_VEC  = 'h3FEC,
  parameter int unsigned ILL_VEC  = 'h3FEE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  input  logic [PC_W-1:0]    cur_pc_i,
  input  logic [15:0]        cur_psw_i,
  input  logic [CNT_W-1:0]   cur_cnt_i,
  input  logic               pc_chg_i,
  input  logic [PC_W-1:0]    tgt_pc_i,
  input  logic [PC_W-1:0]    rpt_start_i,
  input  logic [PC_W-1:0]    rpt_end_i,
  input  logic [PC_W-1:0]    bp_addr_i,
  input  logic               bus_err_i,
  input  logic               ill_ins_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W+1:0]    fetch_o,
  output logic [15:0]        psw_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [PC_W-1:0]    bk_pc_o,
  output logic [15:0]        bk_psw_o
);
  localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_PC);

  logic [PC_W-1:0]  seq_pc, fin_pc;
  logic [PSW_W-1:0] seq_psw, fin_psw;
  logic [CNT_W-1:0] seq_cnt, fin_cnt;
  logic             bk_we;

  pcseq_loop #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
    .pc_i(cur_pc_i), .psw_i(cur_psw_i), .cnt_i(cur_cnt_i),
    .chg_i(pc_chg_i), .tgt_i(tgt_pc_i),
    .start_i(rpt_start_i), .end_i(rpt_end_i),
    .pc_o(seq_pc), .psw_o(seq_psw), .cnt_o(seq_cnt)
  );

  pcseq_trap #(.PC_W(PC_W), .CNT_W(CNT_W), .DBG_VEC(DBG_VEC),
               .BUS_VEC(BUS_VEC), .ILL_VEC(ILL_VEC)) u_trap (
    .pc_i(cur_pc_i), .psw_i(cur_psw_i), .cnt_i(cur_cnt_i),
    .bp_i(bp_addr_i), .bus_i(bus_err_i), .ill_i(ill_ins_i),
    .seq_pc_i(seq_pc), .seq_psw_i(seq_psw), .seq_cnt_i(seq_cnt),
    .pc_o(fin_pc), .psw_o(fin_psw), .cnt_o(fin_cnt), .bk_we_o(bk_we)
  );

  // single writeback per retired word
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o     <= PC_RST;
      fetch_o  <= {PC_RST, 2'b00};
      psw_o    <= '0;
      cnt_o    <= '0;
      bk_pc_o  <= '0;
      bk_psw_o <= '0;
    end else if (step_i) begin
      pc_o    <= fin_pc;
      fetch_o <= {fin_pc, 2'b00};
      psw_o   <= fin_psw;
      cnt_o   <= fin_cnt;
      if (bk_we) begin
        bk_pc_o  <= cur_pc_i;
        bk_psw_o <= cur_psw_i;
      end
    end
  end

  // ---------------- assertions ----------------
  logic exc_req, brk_req;
  assign exc_req = bus_err_i || ill_ins_i;
  assign brk_req = cur_psw_i[B_DB] && (cur_pc_i == bp_addr_i);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pc_o) && $stable(psw_o) && $stable(cnt_o)); // R9
  AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (rst)
    fetch_o == {pc_o, 2'b00}); // R8
  AST_EXC_MASK: assert property (@(posedge clk) disable iff (rst)
    step_i && exc_req |=> (psw_o & ~EXC_KEEP) == '0); // R7
  AST_BUS_VEC: assert property (@(posedge clk) disable iff (rst)
    step_i && bus_err_i |=> pc_o == PC_W'(BUS_VEC)); // R7
  AST_BRK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    step_i && !exc_req && brk_req |=>
      pc_o == PC_W'(DBG_VEC) && bk_pc_o == $past(cur_pc_i) && (psw_o & ~DBG_KEEP) == '0); // R6
  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (rst)
    step_i && !exc_req && !brk_req && !pc_chg_i && cur_psw_i[B_RP] &&
    cur_pc_i == rpt_end_i && cur_cnt_i > CNT_W'(1) |=>
      pc_o == $past(rpt_start_i) && cnt_o == CNT_W'($past(cur_cnt_i) - 1'b1)); // R4
  AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (rst)
    step_i && !exc_req && !brk_req && pc_chg_i |=> pc_o == $past(tgt_pc_i)); // R3
  AST_BK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step_i || exc_req || !brk_req) |=> $stable(bk_pc_o) && $stable(bk_psw_o)); // R10
endmodule

// File: tb/test_pcseq_top.sv
module test_pcseq_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_i;
  logic [15:0] cur_pc_i, cur_psw_i, cur_cnt_i, tgt_pc_i;
  logic [15:0] rpt_start_i, rpt_end_i, bp_addr_i;
  logic        pc_chg_i, bus_err_i, ill_ins_i;
  logic [15:0] pc_o, psw_o, cnt_o, bk_pc_o, bk_psw_o;
  logic [17:0] fetch_o;

  always #2 clk = ~clk;  // 250 MHz

  pcseq_top i_pcseq_top (
    .clk(clk), .rst(rst), .step_i(step_i), .cur_pc_i(cur_pc_i),
    .cur_psw_i(cur_psw_i), .cur_cnt_i(cur_cnt_i), .pc_chg_i(pc_chg_i),
    .tgt_pc_i(tgt_pc_i), .rpt_start_i(rpt_start_i), .rpt_end_i(rpt_end_i),
    .bp_addr_i(bp_addr_i), .bus_err_i(bus_err_i), .ill_ins_i(ill_ins_i),
    .pc_o(pc_o), .fetch_o(fetch_o), .psw_o(psw_o), .cnt_o(cnt_o),
    .bk_pc_o(bk_pc_o), .bk_psw_o(bk_psw_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] e_pc, e_psw, e_cnt, e_bkpc, e_bkpsw;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "pc", {16'h0, pc_o}, {16'h0, e_pc});
    chk(tag, "psw", {16'h0, psw_o}, {16'h0, e_psw});
    chk(tag, "cnt", {16'h0, cnt_o}, {16'h0, e_cnt});
    chk("R8", "fetch", {14'h0, fetch_o}, {14'h0, e_pc, 2'b00});
    chk(tag == "R6" ? "R6" : "R10", "bk_pc", {16'h0, bk_pc_o}, {16'h0, e_bkpc});
    chk(tag == "R6" ? "R6" : "R10", "bk_psw", {16'h0, bk_psw_o}, {16'h0, e_bkpsw});
  endtask

  // drive one retiring word, model the expected result, check one cycle later
  task automatic do_step(logic [15:0] p, logic [15:0] psw, logic [15:0] cnt,
                         bit chg, bit bus, bit ill, logic [15:0] endp, logic [15:0] bpa);
    string tag;
    cur_pc_i = p; cur_psw_i = psw; cur_cnt_i = cnt; pc_chg_i = chg;
    bus_err_i = bus; ill_ins_i = ill; rpt_end_i = endp; bp_addr_i = bpa;
    tgt_pc_i = 16'h0ABC; rpt_start_i = 16'h0100; step_i = 1'b1;
    if (bus || ill) begin
      e_pc = bus ? 16'h3FEC : 16'h3FEE; e_psw = psw & 16'h000D; e_cnt = cnt; tag = "R7";
    end else if (psw[14] && p == bpa) begin
      e_pc = 16'h3FF4; e_psw = psw & 16'h8000; e_cnt = cnt;
      e_bkpc = p; e_bkpsw = psw; tag = "R6";
    end else if (chg) begin
      e_pc = 16'h0ABC; e_psw = psw; e_cnt = cnt; tag = "R3";
    end else if (psw[7] && p == endp) begin
      if (cnt > 16'd1) begin
        e_pc = 16'h0100; e_psw = psw; e_cnt = cnt - 16'd1; tag = "R4";
      end else begin
        e_pc = p + 16'd1; e_psw = psw & ~16'h0080; e_cnt = 16'd0; tag = "R5";
      end
    end else begin
      e_pc = p + 16'd1; e_psw = psw; e_cnt = cnt; tag = "R2";
    end
    @(posedge clk); @(negedge clk);
    check_all(tag);
    // idle cycle with hostile inputs: nothing may move
    step_i = 1'b0; bus_err_i = 1'b1; pc_chg_i = 1'b1;
    cur_psw_i = 16'hFFFF; bp_addr_i = p; cur_pc_i = p;
    @(posedge clk); @(negedge clk);
    check_all("R9");
  endtask

  initial begin
    logic [15:0] cnts [5];
    cnts = '{16'd0, 16'd1, 16'd2, 16'd5, 16'hFFFF};
    rst = 1'b1; step_i = 1'b0; cur_pc_i = '0; cur_psw_i = '0; cur_cnt_i = '0;
    pc_chg_i = 1'b0; tgt_pc_i = '0; rpt_start_i = '0; rpt_end_i = '0;
    bp_addr_i = '0; bus_err_i = 1'b0; ill_ins_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_pc = 16'hFFC0; e_psw = '0; e_cnt = '0; e_bkpc = '0; e_bkpsw = '0;
    check_all("R1");
    chk("R1", "fetch_abs", {14'h0, fetch_o}, 32'h0003FF00);
    rst = 1'b0;
    for (int ps = 0; ps < 2; ps++) begin
      for (int f = 0; f < 128; f++) begin
        for (int c = 0; c < 5; c++) begin
          logic [15:0] p, base, psw;
          p    = (ps == 0) ? 16'h1234 : 16'hFFFF;
          base = (ps == 0) ? 16'h821D : 16'h0162;
          psw  = base | (f[2] ? 16'h0080 : 16'h0) | (f[3] ? 16'h4000 : 16'h0);
          do_step(p, psw, cnts[c], f[4], f[5], f[6],
                  f[0] ? p : p + 16'd3, f[1] ? p : p + 16'd5);
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule